// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic stage of a small 8-bit RISC core. The core presents an operation code, two byte operands (the second one may already be an immediate chosen by the decoder), a high byte for register-pair work and the current status byte. The block returns a registered byte result, a registered high byte, and a registered copy of the status byte in which only the flags that belong to the operation have been rewritten; every other flag is copied from the incoming status byte.

Most operations finish one clock after they are issued. The 16-bit add-immediate and subtract-immediate on a register pair, and the unsigned 8x8 multiply, need two clocks. For those the block raises `busy_o` for one cycle and ignores new requests until the result is delivered. Completion of any operation is marked by a one-cycle `done_o` pulse. The result then stays on the outputs until the next completion.

Top module: `byte_alu_core`

## Requirements
- R1: A synchronous active-high reset clears `res_o`, `res_hi_o`, `sreg_o`, `done_o` and `busy_o` to zero. This also holds when reset is raised in the middle of a two-cycle operation.
- R2: The operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 two's complement, 9 increment, 10 decrement, 11 test, 12 set-bit mask (OR), 13 clear-bit mask (AND with the inverted constant), 14 clear, 15 set-all, 16 word add-immediate, 17 word subtract-immediate, 18 multiply. The status bits run from bit 7 down to bit 0 as I, T, H, S, V, N, Z, C. A one-cycle code issued while `busy_o` is low gives `done_o`=1, its result on `res_o`, `res_hi_o`=0 and its status on `sreg_o` one clock later. I and T are always copied from `sreg_i`.
- R3: For add, add with carry, subtract and subtract with carry, the block rewrites H, S, V, N, Z and C. The carry forms take the incoming C as carry in or as borrow in. H is the carry out of bit 3, or the borrow into bit 3. V is signed overflow, and S = N xor V.
- R4: For subtract with carry, Z is set only when the result is zero and the incoming Z is 1. Otherwise Z is cleared.
- R5: AND, OR, XOR, test, set-bit mask, clear-bit mask and clear rewrite only Z, N, S and V. V is forced to 0. C and H keep their incoming values. Test returns the operand unchanged, and clear returns 0x00.
- R6: Increment and decrement rewrite only Z, N, S and V. V is set exactly on the 0x7F to 0x80 change for increment and on the 0x80 to 0x7F change for decrement.
- R7: One's complement returns 0xFF minus the operand, with C=1 and V=0, and rewrites Z, N, S, V and C. Two's complement returns 0x00 minus the operand and rewrites H, S, V, N, Z and C. In that case C=1 unless the result is 0, V=1 only for a result of 0x80, and H is the borrow into bit 3.
- R8: Set-all returns 0xFF and leaves the status byte equal to `sreg_i`. An undefined code (19 to 31) returns `a_i` and also leaves the status byte unchanged.
- R9: Word add-immediate and word subtract-immediate compute {`hi_i`,`a_i`} plus or minus the unsigned `b_i`. They raise `busy_o` with `done_o`=0 for the first clock and deliver {`res_hi_o`,`res_o`} with `done_o`=1 on the second. They rewrite Z, C, N, V and S over 16 bits and keep H.
- R10: Multiply delivers the unsigned 16-bit product of `a_i` and `b_i` on {`res_hi_o`,`res_o`} after two clocks. It rewrites only Z (product is zero) and C (product bit 15).
- R11: A request presented while `busy_o` is high is ignored. It produces neither a result nor a `done_o` pulse, and `busy_o` never lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Issue the operation on the operand inputs |
| op_i | input | 5 | Operation code (see R2) |
| a_i | input | 8 | First operand; low byte of the pair for word operations |
| b_i | input | 8 | Second operand or immediate constant |
| hi_i | input | 8 | High byte of the register pair for word operations |
| sreg_i | input | 8 | Current status byte |
| res_o | output | 8 | Result byte; low byte of a 16-bit result |
| res_hi_o | output | 8 | High byte of a 16-bit result, 0 for one-cycle operations |
| sreg_o | output | 8 | Updated status byte |
| done_o | output | 1 | One-cycle pulse when a result is delivered |
| busy_o | output | 1 | First cycle of a two-cycle operation; requests are refused |

## Verification
The two functions that can meet in one cycle are the second half of a two-cycle operation and the issue of a new request. A core that does not stall will keep `req_i` high with its next code while the word or multiply stage finishes. The bench provokes this by holding a multiply request and then swapping in an add while `busy_o` is high. It then judges that the multiply product and flags come out untouched and that no second `done_o` pulse, and no add result, follows once the request is dropped. The same boundary is used for reset, which is raised while a multiply is in flight, and the bench checks that nothing is delivered afterwards.

// File: rtl/balu_pkg.sv
package balu_pkg;

    localparam int DATA_W = 8;
    localparam int SREG_W = 8;

    // status bit positions
    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_S = 4;
    localparam int FLAG_H = 5;
    localparam int FLAG_T = 6;
    localparam int FLAG_I = 7;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUB  = 5'd2,
        OP_SUBC = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_TST  = 5'd11,
        OP_SETM = 5'd12,
        OP_CLRM = 5'd13,
        OP_CLR  = 5'd14,
        OP_SER  = 5'd15,
        OP_ADDW = 5'd16,
        OP_SUBW = 5'd17,
        OP_MUL  = 5'd18
    } op_e;

    // one bit per writable flag, used both as write mask and as value
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } flag_set_t;

    function automatic logic is_two_cycle(op_e op);
        return op inside {OP_ADDW, OP_SUBW, OP_MUL};
    endfunction

    function automatic logic uses_adder(op_e op);
        return op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_INC, OP_DEC, OP_NEG};
    endfunction

    function automatic flag_set_t mask_for(op_e op);
        flag_set_t m;
        m = '0;
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG:
                m = '{h: 1'b1, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
            OP_AND, OP_OR, OP_XOR, OP_TST, OP_SETM, OP_CLRM, OP_CLR, OP_INC, OP_DEC:
                m = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0};
            OP_COM, OP_ADDW, OP_SUBW:
                m = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
            OP_MUL:
                m = '{h: 1'b0, s: 1'b0, v: 1'b0, n: 1'b0, z: 1'b1, c: 1'b1};
            default:
                m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [SREG_W-1:0] merge_flags(logic [SREG_W-1:0] base,
                                                      flag_set_t m, flag_set_t f);
        logic [SREG_W-1:0] r;
        r = base;
        if (m.c) r[FLAG_C] = f.c;
        if (m.z) r[FLAG_Z] = f.z;
        if (m.n) r[FLAG_N] = f.n;
        if (m.v) r[FLAG_V] = f.v;
        if (m.s) r[FLAG_S] = f.s;
        if (m.h) r[FLAG_H] = f.h;
        return r;
    endfunction

endpackage

// File: rtl/balu_addsub.sv
module balu_addsub #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half,
    output logic         ovf
);
    localparam int FW = W + 1;
    localparam int PW = NIB + 1;

    logic [FW-1:0] full;
    logic [PW-1:0] part;

    always_comb begin
        if (sub) begin
            full = {1'b0, x} - {1'b0, y} - FW'(cin);
            part = {1'b0, x[NIB-1:0]} - {1'b0, y[NIB-1:0]} - PW'(cin);
        end else begin
            full = {1'b0, x} + {1'b0, y} + FW'(cin);
            part = {1'b0, x[NIB-1:0]} + {1'b0, y[NIB-1:0]} + PW'(cin);
        end
        sum  = full[W-1:0];
        cout = full[W];
        half = part[NIB];
        if (sub)
            ovf = (x[W-1] != y[W-1]) && (sum[W-1] != x[W-1]);
        else
            ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/balu_logic.sv
module balu_logic
    import balu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] val
);
    always_comb begin
        case (op)
            OP_AND:          val = a & b;
            OP_OR, OP_SETM:  val = a | b;
            OP_XOR:          val = a ^ b;
            OP_CLR:          val = '0;
            OP_TST:          val = a;
            OP_CLRM:         val = a & ~b;
            OP_COM:          val = ~a;
            OP_SER:          val = '1;
            default:         val = a;
        endcase
    end
endmodule

// File: rtl/balu_wide.sv
module balu_wide
    import balu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  op_e            op,
    input  logic [W-1:0]   lo,
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   k,
    output logic           busy,
    output logic [2*W-1:0] wres,
    output logic           wc,
    output logic           wv,
    output logic           wz
);
    localparam int HALF = W / 2;
    localparam int PPW  = W + HALF;
    localparam int DW   = 2 * W;
    localparam int EW   = W + 1;

    typedef enum logic [1:0] {WK_ADD, WK_SUB, WK_MUL} wkind_e;

    wkind_e         kind_q;
    logic           busy_q;
    logic [W-1:0]   lo_q;
    logic [W-1:0]   hi_q;
    logic           c1_q;
    logic [PPW-1:0] pp_lo_q;
    logic [PPW-1:0] pp_hi_q;

    // first stage: low byte of the pair, or two nibble-wide partial products
    logic [EW-1:0]  lo_ext;
    logic [PPW-1:0] pp_lo;
    logic [PPW-1:0] pp_hi;
    wkind_e         kind_d;

    always_comb begin
        if (op == OP_SUBW)
            lo_ext = {1'b0, lo} - {1'b0, k};
        else
            lo_ext = {1'b0, lo} + {1'b0, k};
        pp_lo = PPW'(lo) * PPW'(k[HALF-1:0]);
        pp_hi = PPW'(lo) * PPW'(k[W-1:HALF]);
        case (op)
            OP_SUBW: kind_d = WK_SUB;
            OP_MUL:  kind_d = WK_MUL;
            default: kind_d = WK_ADD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            kind_q  <= WK_ADD;
            lo_q    <= '0;
            hi_q    <= '0;
            c1_q    <= 1'b0;
            pp_lo_q <= '0;
            pp_hi_q <= '0;
        end else begin
            busy_q <= start;
            if (start) begin
                kind_q  <= kind_d;
                lo_q    <= lo_ext[W-1:0];
                c1_q    <= lo_ext[W];
                hi_q    <= hi;
                pp_lo_q <= pp_lo;
                pp_hi_q <= pp_hi;
            end
        end
    end

    // second stage: high byte with the stored carry, or the product sum
    logic [EW-1:0] hi_ext;
    logic [DW-1:0] prod;

    always_comb begin
        if (kind_q == WK_SUB)
            hi_ext = {1'b0, hi_q} - EW'(c1_q);
        else
            hi_ext = {1'b0, hi_q} + EW'(c1_q);
        prod = DW'(pp_lo_q) + (DW'(pp_hi_q) << HALF);
        if (kind_q == WK_MUL) begin
            wres = prod;
            wc   = prod[DW-1];
            wv   = 1'b0;
        end else begin
            wres = {hi_ext[W-1:0], lo_q};
            wc   = hi_ext[W];
            if (kind_q == WK_SUB)
                wv = hi_q[W-1] & ~hi_ext[W-1];
            else
                wv = ~hi_q[W-1] & hi_ext[W-1];
        end
        wz = (wres == '0);
    end

    assign busy = busy_q;
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
    import balu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [4:0]        op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [W-1:0]      hi_i,
    input  logic [SREG_W-1:0] sreg_i,
    output logic [W-1:0]      res_o,
    output logic [W-1:0]      res_hi_o,
    output logic [SREG_W-1:0] sreg_o,
    output logic              done_o,
    output logic              busy_o
);
    localparam int DW = 2 * W;

    op_e  op;
    logic busy;
    logic issue;
    logic multi;
    logic start;

    assign op    = op_e'(op_i);
    assign multi = is_two_cycle(op);
    assign issue = req_i && !busy;
    assign start = issue && multi;

    // operand steering for the shared adder/subtractor
    logic [W-1:0] ax, ay;
    logic         acin, asub;

    always_comb begin
        ax   = a_i;
        ay   = b_i;
        acin = 1'b0;
        asub = 1'b0;
        case (op)
            OP_ADDC: acin = sreg_i[FLAG_C];
            OP_SUB:  asub = 1'b1;
            OP_SUBC: begin asub = 1'b1; acin = sreg_i[FLAG_C]; end
            OP_INC:  ay = W'(1);
            OP_DEC:  begin ay = W'(1); asub = 1'b1; end
            OP_NEG:  begin ax = '0; ay = a_i; asub = 1'b1; end
            default: ;
        endcase
    end

    logic [W-1:0] as_sum;
    logic         as_cout, as_half, as_ovf;

    balu_addsub #(.W(W), .NIB(4)) u_addsub (
        .x    (ax),
        .y    (ay),
        .cin  (acin),
        .sub  (asub),
        .sum  (as_sum),
        .cout (as_cout),
        .half (as_half),
        .ovf  (as_ovf)
    );

    logic [W-1:0] lg_val;

    balu_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (a_i),
        .b   (b_i),
        .val (lg_val)
    );

    logic [DW-1:0] wres;
    logic          wc, wv, wz;

    balu_wide #(.W(W)) u_wide (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .op    (op),
        .lo    (a_i),
        .hi    (hi_i),
        .k     (b_i),
        .busy  (busy),
        .wres  (wres),
        .wc    (wc),
        .wv    (wv),
        .wz    (wz)
    );

    // one-cycle result and flags
    logic [W-1:0]      val;
    flag_set_t         nf;
    logic [SREG_W-1:0] single_sreg;

    always_comb begin
        val  = uses_adder(op) ? as_sum : lg_val;
        nf.n = val[W-1];
        nf.v = uses_adder(op) ? as_ovf : 1'b0;
        nf.s = nf.n ^ nf.v;
        nf.h = as_half;
        nf.c = (op == OP_COM) ? 1'b1 : as_cout;
        if (op == OP_SUBC)
            nf.z = (val == '0) && sreg_i[FLAG_Z];
        else
            nf.z = (val == '0);
        single_sreg = merge_flags(sreg_i, mask_for(op), nf);
    end

    // two-cycle flags
    logic [SREG_W-1:0] base_q;
    flag_set_t         wmask_q;
    flag_set_t         wf;

    always_comb begin
        wf.c = wc;
        wf.z = wz;
        wf.v = wv;
        wf.n = wres[DW-1];
        wf.s = wf.n ^ wf.v;
        wf.h = 1'b0;
    end

    logic [W-1:0]      res_q, hi_q;
    logic [SREG_W-1:0] sreg_q;
    logic              done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            hi_q    <= '0;
            sreg_q  <= '0;
            done_q  <= 1'b0;
            base_q  <= '0;
            wmask_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (busy) begin
                res_q  <= wres[W-1:0];
                hi_q   <= wres[DW-1:W];
                sreg_q <= merge_flags(base_q, wmask_q, wf);
                done_q <= 1'b1;
            end else if (issue && !multi) begin
                res_q  <= val;
                hi_q   <= '0;
                sreg_q <= single_sreg;
                done_q <= 1'b1;
            end
            if (start) begin
                base_q  <= sreg_i;
                wmask_q <= mask_for(op);
            end
        end
    end

    assign res_o    = res_q;
    assign res_hi_o = hi_q;
    assign sreg_o   = sreg_q;
    assign done_o   = done_q;
    assign busy_o   = busy;
endmodule

// File: rtl/balu_chk.sv
module balu_chk
    import balu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_i,
    input logic [4:0] op_i,
    input logic [7:0] sreg_i,
    input logic [7:0] res_o,
    input logic [7:0] sreg_o,
    input logic       done_o,
    input logic       busy_o
);
    logic acc;
    assign acc = req_i && !busy_o;

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!done_o && !busy_o && sreg_o == 8'h00));

    assert_single_done_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && !is_two_cycle(op_e'(op_i))) |=> (done_o && !busy_o));

    assert_keep_it_R2: assert property (@(posedge clk) disable iff (rst)
        (acc && !is_two_cycle(op_e'(op_i))) |=>
            (sreg_o[FLAG_I] == $past(sreg_i[FLAG_I]) && sreg_o[FLAG_T] == $past(sreg_i[FLAG_T])));

    assert_subc_z_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && op_i == OP_SUBC && !sreg_i[FLAG_Z]) |=> !sreg_o[FLAG_Z]);

    assert_logic_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (acc && (op_e'(op_i) inside {OP_AND, OP_OR, OP_XOR, OP_TST, OP_SETM, OP_CLRM, OP_CLR})) |=>
            (!sreg_o[FLAG_V] && sreg_o[FLAG_C] == $past(sreg_i[FLAG_C])
             && sreg_o[FLAG_H] == $past(sreg_i[FLAG_H])));

    assert_ser_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && op_i == OP_SER) |=> (res_o == 8'hFF && sreg_o == $past(sreg_i)));

    assert_two_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (acc && is_two_cycle(op_e'(op_i))) |=> (busy_o && !done_o));

    assert_busy_done_R9: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> done_o);

    assert_no_chain_R11: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !busy_o);
endmodule

bind byte_alu_core balu_chk u_chk (.*);

// File: tb/tb_byte_alu_core.sv
module tb_byte_alu_core;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] a_i = '0, b_i = '0, hi_i = '0, sreg_i = '0;
    logic [7:0] res_o, res_hi_o, sreg_o;
    logic       done_o, busy_o;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_alu_core dut (
        .clk(clk), .rst(rst), .req_i(req_i), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .hi_i(hi_i), .sreg_i(sreg_i), .res_o(res_o), .res_hi_o(res_hi_o),
        .sreg_o(sreg_o), .done_o(done_o), .busy_o(busy_o)
    );

    // {op, a, b, status in, expected result, expected status}
    localparam logic [44:0] VECS [NV] = '{
        {5'd0,  8'h0F, 8'h01, 8'h00, 8'h10, 8'h20},  // R3 half carry
        {5'd0,  8'h7F, 8'h01, 8'hC0, 8'h80, 8'hEC},  // R3 overflow, I/T kept
        {5'd1,  8'hFF, 8'h00, 8'h01, 8'h00, 8'h23},  // R3 carry in
        {5'd2,  8'h10, 8'h01, 8'h00, 8'h0F, 8'h20},  // R3 nibble borrow
        {5'd2,  8'h00, 8'h01, 8'h00, 8'hFF, 8'h35},  // R3 borrow
        {5'd3,  8'h05, 8'h05, 8'h00, 8'h00, 8'h00},  // R4 Z not newly set
        {5'd3,  8'h05, 8'h04, 8'h03, 8'h00, 8'h02},  // R4 Z kept
        {5'd4,  8'hF0, 8'h3C, 8'h2F, 8'h30, 8'h21},  // R5 AND
        {5'd6,  8'h80, 8'h01, 8'h00, 8'h81, 8'h14},  // R5 XOR
        {5'd12, 8'h01, 8'h80, 8'h01, 8'h81, 8'h15},  // R5 set-bit mask
        {5'd13, 8'hFF, 8'h0F, 8'h00, 8'hF0, 8'h14},  // R5 clear-bit mask
        {5'd14, 8'h5A, 8'h00, 8'h3D, 8'h00, 8'h23},  // R5 clear
        {5'd11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02},  // R5 test
        {5'd5,  8'h0A, 8'h50, 8'h08, 8'h5A, 8'h00},  // R5 OR clears V
        {5'd9,  8'h7F, 8'h00, 8'h21, 8'h80, 8'h2D},  // R6 inc overflow
        {5'd10, 8'h80, 8'h00, 8'h00, 8'h7F, 8'h18},  // R6 dec overflow
        {5'd10, 8'h01, 8'h00, 8'h00, 8'h00, 8'h02},  // R6 dec to zero
        {5'd7,  8'h55, 8'h00, 8'h00, 8'hAA, 8'h15},  // R7 one's complement
        {5'd8,  8'h01, 8'h00, 8'h00, 8'hFF, 8'h35},  // R7 negate
        {5'd8,  8'h80, 8'h00, 8'h00, 8'h80, 8'h0D},  // R7 negate 0x80
        {5'd8,  8'h00, 8'h00, 8'h3F, 8'h00, 8'h02},  // R7 negate zero
        {5'd15, 8'h12, 8'h00, 8'hA5, 8'hFF, 8'hA5},  // R8 set-all
        {5'd0,  8'h01, 8'h01, 8'hC0, 8'h02, 8'hC0},  // R2 I/T pass
        {5'd31, 8'h3C, 8'h00, 8'h5A, 8'h3C, 8'h5A}   // R8 undefined code
    };

    localparam string TAGS [NV] = '{
        "R3", "R3", "R3", "R3", "R3", "R4", "R4", "R5", "R5", "R5", "R5", "R5",
        "R5", "R5", "R6", "R6", "R6", "R7", "R7", "R7", "R7", "R8", "R2", "R8"
    };

    task automatic check(input string tag, input string what,
                         input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    // drives one request for one edge; returns at the falling edge after it
    task automatic drive(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] hi, input logic [7:0] s);
        @(negedge clk);
        req_i = 1'b1; op_i = op; a_i = a; b_i = b; hi_i = hi; sreg_i = s;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic two_cycle(input string tag, input logic [4:0] op, input logic [7:0] a,
                             input logic [7:0] b, input logic [7:0] hi, input logic [7:0] s,
                             input logic [15:0] exp_res, input logic [7:0] exp_s);
        drive(op, a, b, hi, s);
        check(tag, "busy first cycle", {15'd0, busy_o}, 16'd1);
        check(tag, "no done first cycle", {15'd0, done_o}, 16'd0);
        @(negedge clk);
        check(tag, "done second cycle", {15'd0, done_o}, 16'd1);
        check(tag, "16-bit result", {res_hi_o, res_o}, exp_res);
        check(tag, "status", {8'd0, sreg_o}, {8'd0, exp_s});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [44:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "reset result", {res_hi_o, res_o}, 16'h0000);
        check("R1", "reset status", {8'd0, sreg_o}, 16'h0000);
        check("R1", "reset done/busy", {14'd0, done_o, busy_o}, 16'h0000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            drive(v[44:40], v[39:32], v[31:24], 8'hEE, v[23:16]);
            check(TAGS[i], "done", {15'd0, done_o}, 16'd1);
            check(TAGS[i], "result", {res_hi_o, res_o}, {8'h00, v[15:8]});
            check(TAGS[i], "status", {8'd0, sreg_o}, {8'd0, v[7:0]});
        end

        // R9 word add/subtract immediate
        two_cycle("R9", 5'd16, 8'hFF, 8'h01, 8'h00, 8'h00, 16'h0100, 8'h00);
        two_cycle("R9", 5'd16, 8'hFF, 8'h01, 8'hFF, 8'h20, 16'h0000, 8'h23);
        two_cycle("R9", 5'd16, 8'hFF, 8'h01, 8'h7F, 8'h00, 16'h8000, 8'h0C);
        two_cycle("R9", 5'd17, 8'h00, 8'h01, 8'h00, 8'h00, 16'hFFFF, 8'h15);
        two_cycle("R9", 5'd17, 8'h00, 8'h01, 8'h80, 8'h00, 16'h7FFF, 8'h18);

        // R10 multiply
        two_cycle("R10", 5'd18, 8'hFF, 8'hFF, 8'h00, 8'h1C, 16'hFE01, 8'h1D);
        two_cycle("R10", 5'd18, 8'h00, 8'h37, 8'h00, 8'h01, 16'h0000, 8'h02);
        two_cycle("R10", 5'd18, 8'h12, 8'h34, 8'h00, 8'h00, 16'h03A8, 8'h00);

        // R11 request held through the busy cycle with a different code
        @(negedge clk);
        req_i = 1'b1; op_i = 5'd18; a_i = 8'h10; b_i = 8'h10; sreg_i = 8'h00;
        @(negedge clk);
        op_i = 5'd0; a_i = 8'h01; b_i = 8'h01;
        check("R11", "busy while held", {15'd0, busy_o}, 16'd1);
        @(negedge clk);
        req_i = 1'b0;
        check("R11", "multiply delivered", {res_hi_o, res_o}, 16'h0100);
        check("R11", "multiply status", {8'd0, sreg_o}, 16'h0000);
        @(negedge clk);
        check("R11", "no extra done", {15'd0, done_o}, 16'd0);
        check("R11", "held add not performed", {res_hi_o, res_o}, 16'h0100);

        // R2 high byte returns to zero on a one-cycle operation
        drive(5'd0, 8'h20, 8'h03, 8'h55, 8'h00);
        check("R2", "high byte zero", {res_hi_o, res_o}, 16'h0023);

        // R1 reset during a multiply
        drive(5'd18, 8'hFF, 8'hFF, 8'h00, 8'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "mid-op reset done/busy", {14'd0, done_o, busy_o}, 16'h0000);
        check("R1", "mid-op reset result", {res_hi_o, res_o}, 16'h0000);
        @(negedge clk);
        check("R1", "nothing delivered after reset", {15'd0, done_o}, 16'd0);

        finish_run();
    end
endmodule